// File: doc/BRIEF.md
# Rotating Floating-Point Register Stack

This block holds eight 64-bit floating-point values in a register file that is addressed as a circular stack. A 3-bit top pointer names the current stack top. All stack-relative references are resolved against that pointer, modulo 8. Each physical slot carries an occupancy tag. The block raises a sticky underflow fault when an empty slot is read. It raises a sticky overflow fault when a push lands on an occupied slot.

One command is issued per clock on `op_i`. The available commands are push, pop, stack-relative read, stack-relative write and empty-all. Data returned by a pop or a read appears on `rdata_o` one cycle after the command and holds until the next pop or read. The pointer and the tag vector are visible on ports, so a pipeline can follow stack depth without issuing reads.

Top module: `fp_reg_stack`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it, `top_o` is 0, `tags_o` is 0, `uflow_o` and `oflow_o` are 0 and `rdata_o` is 0.
- R2: Push (`op_i`=1) first decrements the top pointer modulo 8 and then stores `wdata_i` in the slot the new pointer names, marking it full. After reset the first push therefore fills slot 7 (`tags_o` bit n is the tag of physical slot n).
- R3: Pop (`op_i`=2) returns the contents of the slot at the top pointer on `rdata_o` in the next cycle, marks that slot empty and then increments the pointer modulo 8.
- R4: Read (`op_i`=3) of ST(i), with i on `idx_i`, returns physical slot (top + i) mod 8 on `rdata_o` in the next cycle and changes neither pointer nor tags.
- R5: Write (`op_i`=4) of ST(i) stores `wdata_i` in physical slot (top + i) mod 8, marks it full, leaves the pointer unchanged and never raises a fault.
- R6: A push whose target slot is already full sets `oflow_o`; the new value is still stored. No other command sets `oflow_o`.
- R7: A pop or read of an empty slot sets `uflow_o` and returns the quiet-NaN pattern 64'h7FF8_0000_0000_0000 on `rdata_o`; a pop that underflows still increments the pointer.
- R8: `uflow_o` and `oflow_o` are sticky and are cleared only by `flt_clr_i`. A fault event in the same cycle as `flt_clr_i` wins and leaves the flag set.
- R9: Empty-all (`op_i`=5) zeroes every slot, marks all slots empty and returns the pointer to 0, without touching the fault flags.
- R10: Codes 0, 6 and 7 on `op_i` are idle: pointer, tags, flags (absent `flt_clr_i`) and `rdata_o` all hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command: 0 idle, 1 push, 2 pop, 3 read, 4 write, 5 empty-all |
| idx_i | input | 3 | Stack-relative index i for read and write |
| wdata_i | input | 64 | Value for push and write |
| flt_clr_i | input | 1 | Clears both sticky fault flags |
| rdata_o | output | 64 | Registered result of the last pop or read |
| top_o | output | 3 | Current top pointer |
| tags_o | output | 8 | Occupancy tag per physical slot |
| uflow_o | output | 1 | Sticky stack underflow fault |
| oflow_o | output | 1 | Sticky stack overflow fault |

## Verification
A corrupted top pointer becomes visible on `top_o` in the cycle after the faulty push or pop. It also misroutes every later ST(i) read, so the next read returns another slot's value. A wrong tag shows on `tags_o` at once. A tag wrongly cleared yields a NaN and a spurious underflow on the very next read of that slot. A tag wrongly left set can stay silent until a push wraps onto it and raises overflow up to eight pushes later. For that reason the stimulus fills the stack completely and wraps it.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4,
    OP_EMPTY = 3'd5
  } stk_op_e;

  // returned instead of slot contents when an empty slot is read
  localparam logic [63:0] QNAN_PAT = 64'h7FF8_0000_0000_0000;
endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [PW-1:0] top_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] top_q;

  // DEPTH is a power of two, so PW-bit arithmetic wraps modulo DEPTH
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (clr_i)  top_q <= '0;
    else if (push_i) top_q <= top_q - ONE;
    else if (pop_i)  top_q <= top_q + ONE;
  end

  assign top_o = top_q;
endmodule

// File: rtl/fpstk_file.sv
module fpstk_file #(
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PW-1:0]    sel_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             free_en_i,
  input  logic             clr_all_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_tag_o,
  output logic [DEPTH-1:0] tags_o
);
  logic [DEPTH-1:0][DW-1:0] val_flat;
  logic [DEPTH-1:0]         tag_flat;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [DW-1:0] val_q;
    logic          full_q;
    logic          hit;

    assign hit = (sel_i == PW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        full_q <= 1'b0;
      end else if (clr_all_i) begin
        val_q  <= '0;
        full_q <= 1'b0;
      end else if (wr_en_i && hit) begin
        val_q  <= wr_data_i;
        full_q <= 1'b1;
      end else if (free_en_i && hit) begin
        full_q <= 1'b0;
      end
    end

    assign val_flat[s] = val_q;
    assign tag_flat[s] = full_q;
  end

  assign rd_data_o = val_flat[sel_i];
  assign rd_tag_o  = tag_flat[sel_i];
  assign tags_o    = tag_flat;
endmodule

// File: rtl/fpstk_fault.sv
module fpstk_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uf_evt_i,
  input  logic of_evt_i,
  input  logic clr_i,
  output logic uflow_o,
  output logic oflow_o
);
  logic uf_q, of_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q <= 1'b0;
      of_q <= 1'b0;
    end else begin
      uf_q <= uf_evt_i | (uf_q & ~clr_i);
      of_q <= of_evt_i | (of_q & ~clr_i);
    end
  end

  assign uflow_o = uf_q;
  assign oflow_o = of_q;
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
  import fpstk_pkg::*;
#(
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [PW-1:0]    idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             flt_clr_i,
  output logic [DW-1:0]    rdata_o,
  output logic [PW-1:0]    top_o,
  output logic [DEPTH-1:0] tags_o,
  output logic             uflow_o,
  output logic             oflow_o
);
  localparam logic [PW-1:0] ONE     = PW'(1);
  localparam logic [DW-1:0] NAN_VAL = DW'(QNAN_PAT);

  logic do_push, do_pop, do_read, do_write, do_empty;
  logic [PW-1:0] top, sel;
  logic [DW-1:0] slot_data;
  logic          slot_full;
  logic [DW-1:0] rdata_q;

  assign do_push  = (op_i == OP_PUSH);
  assign do_pop   = (op_i == OP_POP);
  assign do_read  = (op_i == OP_READ);
  assign do_write = (op_i == OP_WRITE);
  assign do_empty = (op_i == OP_EMPTY);

  // one physical slot is touched per command
  always_comb begin
    if (do_push)                sel = top - ONE;
    else if (do_read || do_write) sel = top + idx_i;
    else                        sel = top;
  end

  fpstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (do_push),
    .pop_i  (do_pop),
    .clr_i  (do_empty),
    .top_o  (top)
  );

  fpstk_file #(.DW(DW), .DEPTH(DEPTH)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .wr_en_i   (do_push | do_write),
    .wr_data_i (wdata_i),
    .free_en_i (do_pop),
    .clr_all_i (do_empty),
    .rd_data_o (slot_data),
    .rd_tag_o  (slot_full),
    .tags_o    (tags_o)
  );

  fpstk_fault u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uf_evt_i ((do_pop | do_read) & ~slot_full),
    .of_evt_i (do_push & slot_full),
    .clr_i    (flt_clr_i),
    .uflow_o  (uflow_o),
    .oflow_o  (oflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (do_pop || do_read) rdata_q <= slot_full ? slot_data : NAN_VAL;
  end

  assign rdata_o = rdata_q;
  assign top_o   = top;
endmodule

// File: rtl/fpstk_checker.sv
module fpstk_checker
  import fpstk_pkg::*;
#(
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [PW-1:0]    idx_i,
  input logic             flt_clr_i,
  input logic [DW-1:0]    rdata_o,
  input logic [PW-1:0]    top_o,
  input logic [DEPTH-1:0] tags_o,
  input logic             uflow_o,
  input logic             oflow_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] below_top, rd_slot;
  logic          idle_op;
  assign below_top = top_o - ONE;
  assign rd_slot   = top_o + idx_i;
  assign idle_op   = (op_i == OP_IDLE) || (op_i > OP_EMPTY);

  a_r2_push_moves_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_PUSH |=> top_o == $past(below_top) && tags_o[top_o]);

  a_r3_pop_frees_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_POP |=> top_o == $past(top_o) + ONE && !tags_o[below_top]);

  a_r4_read_no_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_READ |=> top_o == $past(top_o) && tags_o == $past(tags_o));

  a_r6_full_push_overflows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_PUSH && tags_o[below_top] |=> oflow_o);

  a_r7_empty_read_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_READ && !tags_o[rd_slot] |=> uflow_o && rdata_o == DW'(QNAN_PAT));

  a_r8_uflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o && !flt_clr_i |=> uflow_o);

  a_r8_oflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oflow_o && !flt_clr_i |=> oflow_o);

  a_r9_empty_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_EMPTY |=> tags_o == '0 && top_o == '0);

  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_op |=> $stable(top_o) && $stable(tags_o) && $stable(rdata_o));
endmodule

bind fp_reg_stack fpstk_checker #(.DW(DW), .DEPTH(DEPTH)) u_fpstk_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .idx_i     (idx_i),
  .flt_clr_i (flt_clr_i),
  .rdata_o   (rdata_o),
  .top_o     (top_o),
  .tags_o    (tags_o),
  .uflow_o   (uflow_o),
  .oflow_o   (oflow_o)
);

// File: tb/fp_reg_stack_tb_top.sv
module fp_reg_stack_tb_top;
  localparam logic [63:0] NAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] VA  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] VB  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] VC  = 64'hC008_0000_0000_0000;

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  op;
    logic [2:0]  idx;
    logic [63:0] wd;
    logic        chk_rd;
    logic [63:0] erd;
    logic [2:0]  etop;
    logic [7:0]  etags;
    logic        euf;
    logic        eof;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 3'd1, 3'd0, VA,   1'b0, 64'd0, 3'd7, 8'h80, 1'b0, 1'b0}, // R2 first push fills slot 7
    '{8'd2, 3'd1, 3'd0, VB,   1'b0, 64'd0, 3'd6, 8'hC0, 1'b0, 1'b0}, // R2
    '{8'd4, 3'd3, 3'd0, 64'd0,1'b1, VB,    3'd6, 8'hC0, 1'b0, 1'b0}, // R4 ST(0)
    '{8'd4, 3'd3, 3'd1, 64'd0,1'b1, VA,    3'd6, 8'hC0, 1'b0, 1'b0}, // R4 ST(1)
    '{8'd5, 3'd4, 3'd2, VC,   1'b0, 64'd0, 3'd6, 8'hC1, 1'b0, 1'b0}, // R5 ST(2) wraps to slot 0
    '{8'd4, 3'd3, 3'd2, 64'd0,1'b1, VC,    3'd6, 8'hC1, 1'b0, 1'b0}, // R4
    '{8'd3, 3'd2, 3'd0, 64'd0,1'b1, VB,    3'd7, 8'h81, 1'b0, 1'b0}, // R3
    '{8'd3, 3'd2, 3'd0, 64'd0,1'b1, VA,    3'd0, 8'h01, 1'b0, 1'b0}, // R3 pointer wraps 7->0
    '{8'd4, 3'd3, 3'd0, 64'd0,1'b1, VC,    3'd0, 8'h01, 1'b0, 1'b0}, // R4
    '{8'd3, 3'd2, 3'd0, 64'd0,1'b1, VC,    3'd1, 8'h00, 1'b0, 1'b0}, // R3
    '{8'd7, 3'd3, 3'd0, 64'd0,1'b1, NAN,   3'd1, 8'h00, 1'b1, 1'b0}  // R7 empty read
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  idx = 3'd0;
  logic [63:0] wd = 64'd0;
  logic        fclr = 1'b0;
  logic [63:0] rdata;
  logic [2:0]  top;
  logic [7:0]  tags;
  logic        uf, of;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_reg_stack dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .idx_i(idx), .wdata_i(wd),
    .flt_clr_i(fclr), .rdata_o(rdata), .top_o(top), .tags_o(tags),
    .uflow_o(uf), .oflow_o(of)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [2:0] i, input logic [63:0] d, input logic c);
    @(negedge clk);
    op = o; idx = i; wd = d; fclr = c;
    @(posedge clk);
    #1;
    op = 3'd0; fclr = 1'b0;
  endtask

  task automatic chk_state(input string req, input logic [2:0] et, input logic [7:0] eg,
                           input logic eu, input logic eo);
    chk(req, "top", 64'(top), 64'(et));
    chk(req, "tags", 64'(tags), 64'(eg));
    chk(req, "uflow", 64'(uf), 64'(eu));
    chk(req, "oflow", 64'(of), 64'(eo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string rq;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk_state("R1", 3'd0, 8'h00, 1'b0, 1'b0);
    chk("R1", "rdata", rdata, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk_state("R1", 3'd0, 8'h00, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      rq = $sformatf("R%0d", VEC[v].req);
      step(VEC[v].op, VEC[v].idx, VEC[v].wd, 1'b0);
      chk_state(rq, VEC[v].etop, VEC[v].etags, VEC[v].euf, VEC[v].eof);
      if (VEC[v].chk_rd) chk(rq, "rdata", rdata, VEC[v].erd);
    end

    // R8 clear, R10 rdata holds on idle
    step(3'd0, 3'd0, 64'd0, 1'b1);
    chk_state("R8", 3'd1, 8'h00, 1'b0, 1'b0);
    chk("R10", "rdata", rdata, NAN);

    // R2/R6 fill all eight slots, then wrap onto a full one
    for (int k = 0; k < 8; k++) step(3'd1, 3'd0, 64'(100 + k), 1'b0);
    chk_state("R2", 3'd1, 8'hFF, 1'b0, 1'b0);
    step(3'd1, 3'd0, 64'hABCD, 1'b0);
    chk_state("R6", 3'd0, 8'hFF, 1'b0, 1'b1);
    step(3'd3, 3'd0, 64'd0, 1'b0);
    chk("R6", "overwritten data", rdata, 64'hABCD);

    // R10 unused codes are idle
    step(3'd6, 3'd2, 64'h55, 1'b0);
    chk_state("R10", 3'd0, 8'hFF, 1'b0, 1'b1);
    chk("R10", "rdata", rdata, 64'hABCD);
    step(3'd7, 3'd5, 64'h66, 1'b0);
    chk_state("R10", 3'd0, 8'hFF, 1'b0, 1'b1);

    // R8 fault in same cycle as clear: set wins
    step(3'd0, 3'd0, 64'd0, 1'b1);
    chk("R8", "oflow cleared", 64'(of), 64'd0);
    step(3'd1, 3'd0, 64'h77, 1'b1);
    chk_state("R8", 3'd7, 8'hFF, 1'b0, 1'b1);

    // R9 empty-all keeps flags
    step(3'd5, 3'd0, 64'd0, 1'b0);
    chk_state("R9", 3'd0, 8'h00, 1'b0, 1'b1);

    // R7 pop of empty slot still advances
    step(3'd2, 3'd0, 64'd0, 1'b0);
    chk_state("R7", 3'd1, 8'h00, 1'b1, 1'b1);
    chk("R7", "rdata", rdata, NAN);
    step(3'd3, 3'd7, 64'd0, 1'b0);
    chk("R7", "rdata ST(7)", rdata, NAN);

    // R5 write raises no fault
    step(3'd0, 3'd0, 64'd0, 1'b1);
    step(3'd4, 3'd3, 64'h1234_5678, 1'b0);
    chk_state("R5", 3'd1, 8'h10, 1'b0, 1'b0);
    step(3'd3, 3'd3, 64'd0, 1'b0);
    chk("R5", "rdata", rdata, 64'h1234_5678);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_state("R1", 3'd0, 8'h00, 1'b0, 1'b0);
    chk("R1", "rdata", rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule